// File: doc/BRIEF.md
# Speed Pulse Glitch Diagnostic

This block watches a speed-sensor pulse stream against a periodic timing tick. It counts ticks between consecutive sensor pulses. A pulse that follows the previous one after too few ticks cannot come from a real wheel at any legal speed, so it is treated as a glitch. A glitch does not raise an error by itself. It only advances a small glitch tally. When the tally reaches its threshold, the block emits a single-cycle error pulse and sets a flag that stays high.

A clear event restarts the whole diagnostic. It empties the tally, drops the held flag and forgets the previous pulse. The block also reports the most recent measured interval, so downstream logic can turn it into a speed. That conversion happens outside this block. The first pulse after reset or after a clear only opens a measurement window. A glitch that arrives right after that first pulse is still counted.

Top module: `spd_glitch_diag`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `err_o`, `err_flag_o`, `gap_o` and `glitch_cnt_o` are all zero.
- R2: The block counts every cycle with `tick_i` high. On each `pulse_i`, `gap_o` takes the number of ticks seen since the previous pulse, from the cycle after the pulse. It then holds that value until the next pulse or clear.
- R3: The running tick count saturates at 2^CNT_W-1 (65535 by default) and does not wrap. A pulse after a longer gap therefore reports 65535.
- R4: The first `pulse_i` after reset or after `clr_i` is never a glitch and leaves `glitch_cnt_o` unchanged.
- R5: Each later pulse whose preceding tick count is below MIN_GAP (6000 by default) is a glitch. It raises `glitch_cnt_o` by one, and the count saturates at ERR_LIMIT (3 by default).
- R6: When a glitch brings `glitch_cnt_o` to ERR_LIMIT, `err_o` is high for exactly one cycle, in the same cycle the count shows ERR_LIMIT. From that cycle on, `err_flag_o` stays high until a clear or reset. Further glitches produce no new `err_o`.
- R7: When a tick and a pulse arrive in the same cycle, the block classifies the pulse using the count before that tick. The tick then counts as the first tick of the new interval.
- R8: `clr_i` takes priority over a pulse or tick in the same cycle. On the next cycle it returns all outputs to zero and re-arms the first-pulse rule.
- R9: A pulse after exactly MIN_GAP ticks is not a glitch. A pulse after MIN_GAP-1 ticks is a glitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Periodic timing tick strobe |
| pulse_i | input | 1 | Speed-sensor pulse strobe |
| clr_i | input | 1 | Clear event for the diagnostic |
| err_o | output | 1 | One-cycle error event |
| err_flag_o | output | 1 | Held error flag |
| gap_o | output | CNT_W | Tick count of the last completed interval |
| glitch_cnt_o | output | GLC_W | Saturating glitch tally |

## Verification
Every result is registered. A strobe sampled at a clock edge shows up in `gap_o`, `glitch_cnt_o`, `err_o` and `err_flag_o` just after that same edge, so it is visible one cycle after the inputs are applied, with no further delay. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It then compares all four outputs on the next falling edge, once per cycle. Each targeted check reads outputs in that same post-edge slot: the error pulse, the saturated count and the boundary gaps. Scenarios include four back-to-back pulses straight after reset, the 5999/6000 boundary, a tick coinciding with a pulse, and a gap longer than the counter range.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

   // Increment with saturation at the all-ones value of the given width.
   function automatic logic [31:0] sat_inc32(input logic [31:0] v, input logic [31:0] max_v);
      return (v >= max_v) ? max_v : v + 32'd1;
   endfunction

   typedef enum logic [0:0] {
      GAP_SATURATE = 1'b0,
      GAP_WRAP     = 1'b1
   } gap_mode_e;

endpackage

// File: rtl/sdg_interval.sv
module sdg_interval
   import sdg_pkg::*;
#(
   parameter int        CNT_W = 16,
   parameter gap_mode_e MODE  = GAP_SATURATE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             pulse,
   output logic [CNT_W-1:0] run_cnt,
   output logic [CNT_W-1:0] last_gap
);

   localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] run_inc;
   logic [CNT_W-1:0] gap_q;

   generate
      if (MODE == GAP_SATURATE) begin : g_sat
         assign run_inc = (run_q == MAX_V) ? MAX_V : run_q + 1'b1;
      end else begin : g_wrap
         assign run_inc = run_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         gap_q <= '0;
      end else if (clr) begin
         run_q <= '0;
         gap_q <= '0;
      end else if (pulse) begin
         gap_q <= run_q;
         run_q <= tick ? {{(CNT_W-1){1'b0}}, 1'b1} : '0;
      end else if (tick) begin
         run_q <= run_inc;
      end
   end

   assign run_cnt  = run_q;
   assign last_gap = gap_q;

endmodule

// File: rtl/sdg_glitch_acc.sv
module sdg_glitch_acc #(
   parameter int LIMIT = 3,
   parameter int CW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          glitch,
   output logic [CW-1:0] cnt,
   output logic          err_pulse,
   output logic          err_flag
);

   localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
   localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;
   logic          err_q;
   logic          flag_q;
   logic          reach;

   assign reach = glitch && (cnt_q == LAST_V) && !flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         err_q  <= 1'b0;
         flag_q <= 1'b0;
      end else if (clr) begin
         cnt_q  <= '0;
         err_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (glitch && (cnt_q != LIM_V))
            cnt_q <= cnt_q + 1'b1;
         err_q  <= reach;
         flag_q <= flag_q | reach;
      end
   end

   assign cnt       = cnt_q;
   assign err_pulse = err_q;
   assign err_flag  = flag_q;

endmodule

// File: rtl/spd_glitch_diag.sv
module spd_glitch_diag
   import sdg_pkg::*;
#(
   parameter int        CNT_W     = 16,
   parameter int        MIN_GAP   = 6000,
   parameter int        ERR_LIMIT = 3,
   parameter gap_mode_e GAP_MODE  = GAP_SATURATE,
   localparam int       GLC_W     = $clog2(ERR_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             pulse_i,
   input  logic             clr_i,
   output logic             err_o,
   output logic             err_flag_o,
   output logic [CNT_W-1:0] gap_o,
   output logic [GLC_W-1:0] glitch_cnt_o
);

   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_GAP);

   generate
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_w
         $error("spd_glitch_diag: CNT_W out of range");
      end
      if (MIN_GAP < 1 || MIN_GAP >= (1 << CNT_W)) begin : g_bad_gap
         $error("spd_glitch_diag: MIN_GAP must fit in CNT_W");
      end
      if (ERR_LIMIT < 1) begin : g_bad_lim
         $error("spd_glitch_diag: ERR_LIMIT must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] run_cnt;
   logic             armed_q;
   logic             glitch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (clr_i)   armed_q <= 1'b0;
      else if (pulse_i) armed_q <= 1'b1;
   end

   assign glitch = pulse_i && !clr_i && armed_q && (run_cnt < MIN_V);

   sdg_interval #(
      .CNT_W (CNT_W),
      .MODE  (GAP_MODE)
   ) u_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_i),
      .tick     (tick_i),
      .pulse    (pulse_i),
      .run_cnt  (run_cnt),
      .last_gap (gap_o)
   );

   sdg_glitch_acc #(
      .LIMIT (ERR_LIMIT),
      .CW    (GLC_W)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_i),
      .glitch    (glitch),
      .cnt       (glitch_cnt_o),
      .err_pulse (err_o),
      .err_flag  (err_flag_o)
   );

endmodule

// File: rtl/sdg_chk.sv
module sdg_chk #(
   parameter int CNT_W     = 16,
   parameter int ERR_LIMIT = 3,
   parameter int GLC_W     = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pulse_i,
   input logic             clr_i,
   input logic             err_o,
   input logic             err_flag_o,
   input logic [CNT_W-1:0] gap_o,
   input logic [GLC_W-1:0] glitch_cnt_o
);

   localparam logic [GLC_W-1:0] LIM_V = GLC_W'(ERR_LIMIT);

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o); // R6

   AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (glitch_cnt_o == LIM_V) && err_flag_o); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag_o && !clr_i) |=> err_flag_o); // R6

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      glitch_cnt_o <= LIM_V); // R5

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !pulse_i) |=> $stable(glitch_cnt_o)); // R5

   AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !pulse_i) |=> $stable(gap_o)); // R2

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (glitch_cnt_o == '0) && !err_flag_o && !err_o && (gap_o == '0)); // R8

endmodule

bind spd_glitch_diag sdg_chk #(
   .CNT_W     (CNT_W),
   .ERR_LIMIT (ERR_LIMIT),
   .GLC_W     (GLC_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pulse_i      (pulse_i),
   .clr_i        (clr_i),
   .err_o        (err_o),
   .err_flag_o   (err_flag_o),
   .gap_o        (gap_o),
   .glitch_cnt_o (glitch_cnt_o)
);

// File: tb/spd_glitch_diag_test.sv
`timescale 1ns/1ps
module spd_glitch_diag_test;

   localparam int CNT_W = 16;
   localparam int MIN_GAP = 6000;
   localparam int LIMIT = 3;
   localparam int GLC_W = 2;
   localparam int MAXC = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0, pulse_i = 1'b0, clr_i = 1'b0;
   logic err_o, err_flag_o;
   logic [CNT_W-1:0] gap_o;
   logic [GLC_W-1:0] glitch_cnt_o;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   // behavioural reference state
   int m_run = 0, m_gap = 0, m_cnt = 0;
   bit m_err = 0, m_flag = 0, m_armed = 0;

   always #5 clk = ~clk;

   spd_glitch_diag uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pulse_i(pulse_i), .clr_i(clr_i),
      .err_o(err_o), .err_flag_o(err_flag_o), .gap_o(gap_o), .glitch_cnt_o(glitch_cnt_o)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_update(bit t, bit p, bit c);
      if (c) begin
         m_run = 0; m_gap = 0; m_cnt = 0; m_err = 0; m_flag = 0; m_armed = 0;
      end else begin
         m_err = 0;
         if (p) begin
            m_gap = m_run;
            if (m_armed && m_run < MIN_GAP) begin
               if (m_cnt < LIMIT) m_cnt++;
               if (m_cnt == LIMIT && !m_flag) begin
                  m_err = 1; m_flag = 1;
               end
            end
            m_armed = 1;
            m_run = t ? 1 : 0;
         end else if (t && m_run < MAXC) begin
            m_run++;
         end
      end
   endtask

   task automatic compare(string tag);
      chk({tag, " err_o"}, int'(err_o), int'(m_err));
      chk({tag, " err_flag_o"}, int'(err_flag_o), int'(m_flag));
      chk({tag, " gap_o"}, int'(gap_o), m_gap);
      chk({tag, " glitch_cnt_o"}, int'(glitch_cnt_o), m_cnt);
   endtask

   // one clock cycle: drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step(bit t, bit p, bit c, string tag);
      tick_i = t; pulse_i = p; clr_i = c;
      @(posedge clk);
      model_update(t, p, c);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic ticks(int n, string tag);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, tag);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      compare("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b0, "R1 after release");

      // R4: first pulse arms only; then three immediate glitches (four pulses, no tick)
      step(1'b0, 1'b1, 1'b0, "R4 first pulse");
      chk("R4 no glitch on first pulse", int'(glitch_cnt_o), 0);
      step(1'b0, 1'b1, 1'b0, "R5 glitch one");
      chk("R5 count after first glitch", int'(glitch_cnt_o), 1);
      step(1'b0, 1'b1, 1'b0, "R5 glitch two");
      step(1'b0, 1'b1, 1'b0, "R6 glitch three");
      chk("R6 err pulse on third glitch", int'(err_o), 1);
      chk("R6 count at limit", int'(glitch_cnt_o), 3);
      step(1'b0, 1'b0, 1'b0, "R6 idle");
      chk("R6 err lasts one cycle", int'(err_o), 0);
      chk("R6 flag held", int'(err_flag_o), 1);
      step(1'b0, 1'b1, 1'b0, "R5 saturate");
      chk("R5 count saturates", int'(glitch_cnt_o), 3);
      chk("R6 no second err", int'(err_o), 0);

      // R8: clear with simultaneous pulse and tick
      step(1'b1, 1'b1, 1'b1, "R8 clear");
      chk("R8 flag cleared", int'(err_flag_o), 0);
      chk("R8 count cleared", int'(glitch_cnt_o), 0);
      step(1'b0, 1'b1, 1'b0, "R8 re-armed first pulse");
      chk("R8 first pulse after clear not glitch", int'(glitch_cnt_o), 0);

      // R9 boundary: 5999 is a glitch, 6000 is not
      ticks(MIN_GAP - 1, "R2 ticks");
      step(1'b0, 1'b1, 1'b0, "R9 gap 5999");
      chk("R9 5999 gap reported", int'(gap_o), MIN_GAP - 1);
      chk("R9 5999 is glitch", int'(glitch_cnt_o), 1);
      ticks(MIN_GAP, "R2 ticks");
      step(1'b0, 1'b1, 1'b0, "R9 gap 6000");
      chk("R2 6000 gap reported", int'(gap_o), MIN_GAP);
      chk("R9 6000 not glitch", int'(glitch_cnt_o), 1);

      // R7: tick coinciding with pulse
      ticks(MIN_GAP - 1, "R7 ticks");
      step(1'b1, 1'b1, 1'b0, "R7 tick with pulse");
      chk("R7 compare before tick", int'(glitch_cnt_o), 2);
      chk("R7 gap excludes tick", int'(gap_o), MIN_GAP - 1);
      ticks(MIN_GAP - 1, "R7 ticks");
      step(1'b0, 1'b1, 1'b0, "R7 next pulse");
      chk("R7 tick counted in new interval", int'(gap_o), MIN_GAP);
      chk("R7 no glitch on 6000", int'(glitch_cnt_o), 2);

      // R3: saturation of the interval counter
      ticks(MAXC + 4000, "R3 ticks");
      step(1'b0, 1'b1, 1'b0, "R3 long gap");
      chk("R3 gap saturates", int'(gap_o), MAXC);
      chk("R3 long gap not glitch", int'(glitch_cnt_o), 2);

      step(1'b0, 1'b0, 1'b0, "end");
      done = 1;
      summary();
      $finish;
   end

endmodule